// File: doc/BRIEF.md
# Compare-Clear Timer / Event Counter

This block is an up-counter whose value is compared against a programmable compare register. The counter advances on one of two tick sources. The first is an internal count-clock enable that comes from a free-running divider. The second is a rising edge seen on an external event pin, after that pin passes through a two-flop synchroniser. When the counter equals the compare value on a tick, it returns to zero on that same tick. The block then raises a one-cycle match pulse and sets a sticky match status bit.

Software controls the block with a run bit, a source select and a compare write strobe. It reads the live count and the two match outputs. While run is low, the counter is held at zero and event edges are not counted. Raising run does not realign the divider, so the first internal tick lands anywhere within one count-clock period. A compare write loads at the next clock edge and has no shadow register. If a new compare value is below the current count, the counter runs on through all-ones and wraps before it can match. To avoid this, software lowers the compare value only while the timer is stopped.

All pins are plain control and status signals. No port carries a data stream, so there is no valid/ready handshake and no back-pressure.

Top module: `evt_timer`

## Requirements
- R1: During and after reset, `count` is 0, `match_pulse` is 0 and `match_sticky` is 0.
- R2: While `run` is 0, `count` reads 0 from the next clock on. Event pin edges that occur while `run` is 0 are never counted, including after `run` rises again.
- R3: With `src_sel`=0 and `run`=1, `count` increases by exactly one on each internal tick. Internal ticks occur once every `PRESC_DIV` clocks, and `count` holds between ticks.
- R4: On a tick where `count` equals the compare value, `count` becomes 0 and `match_pulse` is 1 for exactly one clock. The match period is therefore (compare+1) ticks.
- R5: `match_sticky` is set by every match and cleared by `sticky_clr`=1. If both happen in the same cycle, the set wins.
- R6: With `src_sel`=1, each rising edge on `evt_in` adds exactly one. A rise driven before clock edge k shows in `count` after edge k+2.
- R7: A compare write with data 0 is ignored, and the previous compare value stays in force.
- R8: A nonzero compare write takes effect at the next clock edge. If the new value is below `count`, the counter continues to all-ones, wraps to 0, and matches only when it reaches the new value.
- R9: The internal divider keeps running while the timer is stopped and is not reset by `run`. With compare value C, the first match after `run` rises comes between C*PRESC_DIV+1 and (C+1)*PRESC_DIV clocks later.
- R10: The source not selected by `src_sel` has no effect. With `src_sel`=1, internal ticks are not counted. With `src_sel`=0, `evt_in` edges are not counted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run | input | 1 | 1 = counting, 0 = stopped and cleared |
| src_sel | input | 1 | 0 = internal divided tick, 1 = external event edges |
| cmp_wr | input | 1 | Compare register write strobe |
| cmp_wdata | input | CNT_W | Compare value to write (0 is ignored) |
| evt_in | input | 1 | Asynchronous external event pin |
| sticky_clr | input | 1 | 1 clears the sticky match bit |
| count | output | CNT_W | Live counter value |
| match_pulse | output | 1 | One-cycle pulse on each compare match |
| match_sticky | output | 1 | Latched match status |

## Verification
A wrong count step or a missed match shows at the `count` port on the next tick. It also stretches or shortens the interval between `match_pulse` assertions by at least one count-clock period, so a measured period exposes it within one cycle of the expected match. A compare register that loaded a zero, or that missed a lowered value, changes where the counter clears: it either clears early or fails to climb to all-ones before wrapping. A faulty synchroniser or gating of the run bit shows up as a count that moves while the timer is stopped, or one or two cycles off the expected event latency.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  typedef enum logic {
    SRC_DIVIDED = 1'b0,
    SRC_EVENT   = 1'b1
  } tick_src_e;
endpackage

// File: rtl/tmr_prescaler.sv
module tmr_prescaler #(
  parameter int DIV = 4
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  generate
    if (DIV <= 1) begin : g_pass
      assign tick = 1'b1;
    end else begin : g_div
      localparam int PW = $clog2(DIV);
      localparam logic [PW-1:0] LAST = PW'(DIV - 1);
      logic [PW-1:0] phase;
      // free-running: phase is deliberately not touched by run
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)              phase <= '0;
        else if (phase == LAST)  phase <= '0;
        else                     phase <= phase + 1'b1;
      end
      assign tick = (phase == LAST);
    end
  endgenerate
endmodule

// File: rtl/tmr_evt_sync.sv
module tmr_evt_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic pin,
  output logic rise
);
  logic meta_q, sync_q, prev_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= 1'b0;
      sync_q <= 1'b0;
      prev_q <= 1'b0;
    end else begin
      meta_q <= pin;
      sync_q <= meta_q;
      prev_q <= sync_q;
    end
  end
  assign rise = sync_q & ~prev_q;
endmodule

// File: rtl/tmr_core.sv
module tmr_core #(
  parameter int              W       = 16,
  parameter logic [W-1:0]    CMP_RST = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         run,
  input  logic         tick,
  input  logic         cmp_wr,
  input  logic [W-1:0] cmp_wdata,
  input  logic         sticky_clr,
  output logic [W-1:0] count,
  output logic [W-1:0] cmp_q,
  output logic         match_pulse,
  output logic         match_sticky
);
  logic hit, fire;

  assign hit  = (count == cmp_q);
  assign fire = run & tick & hit;

  // compare register: direct load, zero rejected
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                          cmp_q <= CMP_RST;
    else if (cmp_wr && cmp_wdata != '0)  cmp_q <= cmp_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         count <= '0;
    else if (!run)      count <= '0;
    else if (tick)      count <= hit ? '0 : count + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      match_pulse  <= 1'b0;
      match_sticky <= 1'b0;
    end else begin
      match_pulse  <= fire;
      match_sticky <= fire | (match_sticky & ~sticky_clr);
    end
  end
endmodule

// File: rtl/evt_timer.sv
module evt_timer #(
  parameter int                 CNT_W     = 16,
  parameter int                 PRESC_DIV = 4,
  parameter logic [CNT_W-1:0]   CMP_RST   = '1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             src_sel,
  input  logic             cmp_wr,
  input  logic [CNT_W-1:0] cmp_wdata,
  input  logic             evt_in,
  input  logic             sticky_clr,
  output logic [CNT_W-1:0] count,
  output logic             match_pulse,
  output logic             match_sticky
);
  import tmr_pkg::*;

  tick_src_e        src;
  logic             div_tick, evt_rise, tick;
  logic [CNT_W-1:0] cmp_q;

  assign src  = tick_src_e'(src_sel);
  assign tick = (src == SRC_EVENT) ? evt_rise : div_tick;

  tmr_prescaler #(.DIV(PRESC_DIV)) u_div (
    .clk(clk), .rst_n(rst_n), .tick(div_tick)
  );

  tmr_evt_sync u_sync (
    .clk(clk), .rst_n(rst_n), .pin(evt_in), .rise(evt_rise)
  );

  tmr_core #(.W(CNT_W), .CMP_RST(CMP_RST)) u_core (
    .clk(clk), .rst_n(rst_n), .run(run), .tick(tick),
    .cmp_wr(cmp_wr), .cmp_wdata(cmp_wdata), .sticky_clr(sticky_clr),
    .count(count), .cmp_q(cmp_q),
    .match_pulse(match_pulse), .match_sticky(match_sticky)
  );
endmodule

// File: rtl/tmr_chk.sv
module tmr_chk #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst_n,
  input logic         run,
  input logic         cmp_wr,
  input logic [W-1:0] cmp_wdata,
  input logic         sticky_clr,
  input logic [W-1:0] count,
  input logic [W-1:0] cmp_q,
  input logic         match_pulse,
  input logic         match_sticky
);
  p_stop_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (count == '0));

  p_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (count != $past(count)) |-> (count == '0 || count == $past(count) + 1'b1));

  p_clear_on_match_r4: assert property (@(posedge clk) disable iff (!rst_n)
    match_pulse |-> (count == '0));

  p_single_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
    match_pulse |=> !match_pulse);

  p_sticky_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
    match_pulse |-> match_sticky);

  p_sticky_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
    sticky_clr |=> (!match_sticky || match_pulse));

  p_zero_ignored_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_wr && cmp_wdata == '0) |=> $stable(cmp_q));

  p_cmp_load_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_wr && cmp_wdata != '0) |=> (cmp_q == $past(cmp_wdata)));
endmodule

bind evt_timer tmr_chk #(.W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .run(run), .cmp_wr(cmp_wr),
  .cmp_wdata(cmp_wdata), .sticky_clr(sticky_clr), .count(count),
  .cmp_q(cmp_q), .match_pulse(match_pulse), .match_sticky(match_sticky)
);

// File: tb/evt_timer_bench.sv
module evt_timer_bench;
  localparam int CLK_P = 10;
  localparam int W     = 12;
  localparam int DIV   = 3;
  localparam int ALL1  = (1 << W) - 1;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         run = 1'b0, src_sel = 1'b0, cmp_wr = 1'b0;
  logic [W-1:0] cmp_wdata = '0;
  logic         evt_in = 1'b0, sticky_clr = 1'b0;
  logic [W-1:0] count;
  logic         match_pulse, match_sticky;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  evt_timer #(.CNT_W(W), .PRESC_DIV(DIV)) u_evt_timer (
    .clk(clk), .rst_n(rst_n), .run(run), .src_sel(src_sel),
    .cmp_wr(cmp_wr), .cmp_wdata(cmp_wdata), .evt_in(evt_in),
    .sticky_clr(sticky_clr), .count(count),
    .match_pulse(match_pulse), .match_sticky(match_sticky)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic set_cmp(input int v);
    cmp_wr = 1'b1; cmp_wdata = W'(v);
    @(negedge clk);
    cmp_wr = 1'b0;
  endtask

  task automatic wait_match(input int limit, output int n);
    n = 0;
    while (n < limit) begin
      @(negedge clk);
      n++;
      if (match_pulse) return;
    end
    n = -1;
  endtask

  task automatic t_reset;
    step(3);
    chk(count == 0 && !match_pulse && !match_sticky, "R1 in reset", int'(count), 0);
    rst_n = 1'b1;
    step(3);
    chk(count == 0, "R1 count after reset", int'(count), 0);
    chk(!match_pulse && !match_sticky, "R1 flags after reset",
        int'({match_pulse, match_sticky}), 0);
  endtask

  task automatic t_internal;
    int n;
    run = 1'b0; src_sel = 1'b0; step(2);
    set_cmp(5);
    run = 1'b1;
    wait_match(200, n);
    chk(n > 0, "R4 first match seen", n, 1);
    chk(count == 0, "R4 count cleared at match", int'(count), 0);
    step(1);
    chk(!match_pulse, "R4 pulse one cycle", int'(match_pulse), 0);
    step(1);
    chk(count == 0, "R3 holds between ticks", int'(count), 0);
    step(1);
    chk(count == 1, "R3 one step per tick", int'(count), 1);
    wait_match(200, n);
    chk(n == 15, "R4 period (C+1)*DIV", n + 3, 18);
  endtask

  task automatic t_start_window;
    int n;
    int seen [3];
    for (int off = 0; off < 3; off++) begin
      run = 1'b0; step(5 + off);
      run = 1'b1;
      wait_match(200, n);
      seen[off] = n;
      chk(n >= 5*DIV + 1 && n <= 6*DIV, "R9 first match window", n, 5*DIV + 1);
    end
    chk(seen[0] != seen[1] || seen[1] != seen[2], "R9 divider phase not realigned",
        seen[0], seen[1]);
  endtask

  task automatic t_sticky;
    int n;
    run = 1'b0; step(2);
    sticky_clr = 1'b1; step(1); sticky_clr = 1'b0;
    chk(!match_sticky, "R5 clear", int'(match_sticky), 0);
    sticky_clr = 1'b1;
    run = 1'b1;
    wait_match(200, n);
    chk(match_sticky, "R5 set wins over clear", int'(match_sticky), 1);
    step(1);
    chk(!match_sticky, "R5 clear after match", int'(match_sticky), 0);
    sticky_clr = 1'b0;
  endtask

  task automatic t_zero_write;
    int n;
    run = 1'b0; step(2);
    set_cmp(4);
    set_cmp(0);
    run = 1'b1;
    wait_match(200, n);
    wait_match(200, n);
    chk(n == 5*DIV, "R7 zero write ignored", n, 5*DIV);
  endtask

  task automatic t_external;
    run = 1'b0; src_sel = 1'b1; evt_in = 1'b0; step(2);
    set_cmp(100);
    for (int i = 0; i < 4; i++) begin
      evt_in = 1'b1; step(2); evt_in = 1'b0; step(2);
    end
    chk(count == 0, "R2 edges ignored while stopped", int'(count), 0);
    run = 1'b1; step(4);
    chk(count == 0, "R2 no stale edge on start", int'(count), 0);
    evt_in = 1'b1;
    step(2);
    chk(count == 0, "R6 latency not early", int'(count), 0);
    step(1);
    chk(count == 1, "R6 latency three edges", int'(count), 1);
    evt_in = 1'b0; step(2);
    for (int i = 0; i < 6; i++) begin
      evt_in = 1'b1; step(2); evt_in = 1'b0; step(2);
    end
    step(4);
    chk(count == 7, "R6 one count per edge", int'(count), 7);
    step(30);
    chk(count == 7, "R10 divider ignored in event mode", int'(count), 7);
  endtask

  task automatic t_src_internal;
    run = 1'b0; src_sel = 1'b0; step(2);
    run = 1'b1;
    for (int i = 0; i < 15; i++) begin
      evt_in = 1'b1; step(1); evt_in = 1'b0; step(1);
    end
    chk(count == 10, "R10 events ignored in divided mode", int'(count), 10);
  endtask

  task automatic t_wrap;
    int n;
    int maxc;
    run = 1'b0; src_sel = 1'b0; step(2);
    set_cmp(200);
    run = 1'b1;
    n = 0;
    while (count < 50 && n < 1000) begin step(1); n++; end
    set_cmp(10);
    maxc = 0;
    n = 0;
    while (!match_pulse && n < 20000) begin
      step(1); n++;
      if (int'(count) > maxc) maxc = int'(count);
    end
    chk(maxc == ALL1, "R8 runs through all-ones", maxc, ALL1);
    chk(match_pulse && count == 0, "R8 matches after wrap", int'(match_pulse), 1);
    wait_match(200, n);
    chk(n == 11*DIV, "R8 new period", n, 11*DIV);
  endtask

  initial begin
    t_reset();
    t_internal();
    t_start_window();
    t_sticky();
    t_zero_write();
    t_external();
    t_src_internal();
    t_wrap();
    run = 1'b0;
    step(2);
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++; errors++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule